// File: doc/BRIEF.md
# Three-Wire Serial Memory Controller

This block is the slave side of a three-wire serial memory port with select (`cs_i`), serial clock (`sk_i`), serial data in (`di_i`) and serial data out (`do_o` with its enable `do_oe_o`). It fronts a 1 kbit store that is modelled as registers. The store holds 128 eight-bit units, or 64 sixteen-bit units when `WORD16` is set. All port inputs are sampled by the system clock `clk`. A rising serial clock is found by edge detection, and only while select is high.

A host raises select and sends a frame. The frame opens with a single 1 and carries a two-bit opcode and then an address, both most significant bit first. A write frame carries data after the address. A read frame returns data on `do_o`, and the reply keeps running through higher addresses for as long as the host keeps clocking. Alteration commands are held back until select falls. They then start a self-timed programming cycle of `PROG_CYCLES` system clocks. While that cycle runs, the block shows busy or ready on `do_o` whenever it is selected.

Top module: `mw_serial_mem`

## Requirements
- R1: Frame layout. DI is taken on each rising SK edge while CS is high. Zeros that come before the first 1 are skipped. The first 1 is the start bit. Two opcode bits follow it, then 7 address bits (x8) or 6 address bits (x16). Opcode and address are sent MSB first.
- R2: Opcode 10 is read, 01 is write and 11 is erase. Opcode 00 takes its meaning from the two top address bits: 11 enables alteration, 00 disables it, 10 erases every location and 01 writes one data unit to every location.
- R3: A read first drives DO to 0, at the rising SK edge that carries the last address bit. Each following rising SK edge then presents one data bit, MSB first.
- R4: If CS stays high and SK keeps running after a full read unit, the next higher address is sent with no dummy bit in between. The address after the top location is 0.
- R5: After reset, alteration is disabled. While it is disabled, write, erase, erase-all and write-all have no effect on the store and start no cycle. The enable command switches alteration on and the disable command switches it off. Reads work in either state.
- R6: A store change happens only when CS falls, and only if at least one complete data unit arrived. Erase sets a location to all ones. Erase-all and write-all act on every location.
- R7: Data units after the first in one write frame go to successive addresses. Only the low 4 address bits (x8) or the low 3 address bits (x16) wrap, so the writes stay inside one page.
- R8: A cycle lasts PROG_CYCLES system clocks. While CS is high during the cycle, DO is driven low. Once the cycle ends, DO is driven high. No SK activity is needed for this.
- R9: The ready level stays on DO every time CS is high, across any number of deselects, until a start bit is clocked in.
- R10: Any frame sent while a cycle is running is ignored, including an enable or disable command.
- R11: DO is released (`do_oe_o` low) whenever CS is low, and whenever no read reply and no status is being shown. Lowering CS in the middle of a frame abandons the frame.
- R12: After reset, every location reads as all ones and DO is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_i | input | 1 | Select, active high |
| sk_i | input | 1 | Serial clock |
| di_i | input | 1 | Serial data in |
| do_o | output | 1 | Serial data out value |
| do_oe_o | output | 1 | Serial data out drive enable |

## Verification
The assertions assume that `cs_i`, `sk_i` and `di_i` change only between system clock edges, with each level held for at least one clock. They also assume that a data unit is never delivered at the same time as a cycle start. The bench changes all three inputs on the falling system clock edge and holds every SK level for two clocks. It lowers CS only between frames or on purpose to abandon one, and it samples `do_o` only while SK is low.

// File: rtl/mw_pkg.sv
`timescale 1ns/1ps
package mw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_OPC, ST_ADDR, ST_DATA, ST_READ, ST_HOLD
  } mw_state_e;

  typedef enum logic [2:0] {
    CMD_NONE, CMD_READ, CMD_WRITE, CMD_ERASE,
    CMD_EWEN, CMD_EWDS, CMD_ERAL, CMD_WRAL
  } mw_cmd_e;

  // opcode plus the two top address bits select the command
  function automatic mw_cmd_e decode_cmd(input logic [1:0] opc, input logic [1:0] sel);
    case (opc)
      2'b10: return CMD_READ;
      2'b01: return CMD_WRITE;
      2'b11: return CMD_ERASE;
      default: begin
        case (sel)
          2'b11:   return CMD_EWEN;
          2'b00:   return CMD_EWDS;
          2'b10:   return CMD_ERAL;
          default: return CMD_WRAL;
        endcase
      end
    endcase
  endfunction

  // modular increment used for page slots and address roll-over
  function automatic int unsigned wrap_inc(input int unsigned v, input int unsigned span);
    return (v + 1) % span;
  endfunction

endpackage

// File: rtl/mw_bus_sampler.sv
`timescale 1ns/1ps
module mw_bus_sampler (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_i,
  input  logic sk_i,
  output logic sk_rise,
  output logic cs_fall
);
  logic cs_q, sk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q <= 1'b0;
      sk_q <= 1'b0;
    end else begin
      cs_q <= cs_i;
      sk_q <= sk_i;
    end
  end

  assign sk_rise = cs_i & sk_i & ~sk_q;
  assign cs_fall = cs_q & ~cs_i;
endmodule

// File: rtl/mw_prog_timer.sv
`timescale 1ns/1ps
module mw_prog_timer #(
  parameter int unsigned CYCLES = 2000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int unsigned CTW = $clog2(CYCLES + 1);
  logic [CTW-1:0] count;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               count <= '0;
    else if (start)           count <= CTW'(CYCLES);
    else if (count != '0)     count <= count - 1'b1;
  end

  assign busy = (count != '0);
  assign done = (count == CTW'(1));

  // a new cycle is never launched on top of a running one
  p_no_restart_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);
endmodule

// File: rtl/mw_store.sv
`timescale 1ns/1ps
module mw_store #(
  parameter int unsigned AW = 7,
  parameter int unsigned DW = 8,
  parameter int unsigned PB = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   commit,
  input  logic                   commit_all,
  input  logic [DW-1:0]          all_val,
  input  logic [AW-PB-1:0]       pg_base,
  input  logic [(1<<PB)-1:0]     pg_valid,
  input  logic [(1<<PB)*DW-1:0]  pg_data,
  input  logic [AW-1:0]          rd_addr,
  output logic [DW-1:0]          rd_word
);
  localparam int unsigned DEPTH = 1 << AW;
  localparam int unsigned SLOTS = 1 << PB;
  localparam int unsigned BW    = AW - PB;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (commit_all)
          mem[i] <= all_val;
        else if (commit && pg_valid[i % SLOTS] && (pg_base == BW'(i / SLOTS)))
          mem[i] <= pg_data[(i % SLOTS)*DW +: DW];
      end
    end
  end

  assign rd_word = mem[rd_addr];
endmodule

// File: rtl/mw_serial_mem.sv
`timescale 1ns/1ps
module mw_serial_mem #(
  parameter bit          WORD16      = 1'b0,
  parameter int unsigned PROG_CYCLES = 2000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_i,
  input  logic sk_i,
  input  logic di_i,
  output logic do_o,
  output logic do_oe_o
);
  import mw_pkg::*;

  localparam int unsigned AW    = WORD16 ? 6 : 7;
  localparam int unsigned DW    = WORD16 ? 16 : 8;
  localparam int unsigned PB    = WORD16 ? 3 : 4;
  localparam int unsigned SLOTS = 1 << PB;
  localparam int unsigned DEPTH = 1 << AW;
  localparam int unsigned CW    = 5;
  localparam logic [CW-1:0] ADDR_LAST = CW'(AW - 1);
  localparam logic [CW-1:0] DATA_LAST = CW'(DW - 1);
  localparam logic [CW-1:0] DATA_CNT  = CW'(DW);

  // internal events, named for the checks below
  logic sk_rise, cs_fall, busy, prog_done, prog_start, rd_active;

  mw_state_e        state;
  mw_cmd_e          cmd;
  mw_cmd_e          cmd_now;
  logic [CW-1:0]    cnt;
  logic [1:0]       opc;
  logic [AW-1:0]    addr, addr_shift, rd_addr;
  logic [DW-1:0]    sh, data_shift, rd_word, all_val;
  logic             out_bit, wen, rdy, pend_page, pend_all;
  logic [PB-1:0]    ptr;
  logic [AW-PB-1:0] pg_base;
  logic [SLOTS-1:0] pg_valid;
  logic [SLOTS*DW-1:0] pg_data;

  mw_bus_sampler u_sampler (
    .clk(clk), .rst_n(rst_n), .cs_i(cs_i), .sk_i(sk_i),
    .sk_rise(sk_rise), .cs_fall(cs_fall)
  );

  mw_prog_timer #(.CYCLES(PROG_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(prog_start), .busy(busy), .done(prog_done)
  );

  mw_store #(.AW(AW), .DW(DW), .PB(PB)) u_store (
    .clk(clk), .rst_n(rst_n),
    .commit(prog_start & pend_page), .commit_all(prog_start & pend_all),
    .all_val(all_val), .pg_base(pg_base), .pg_valid(pg_valid), .pg_data(pg_data),
    .rd_addr(rd_addr), .rd_word(rd_word)
  );

  assign addr_shift = {addr[AW-2:0], di_i};
  assign data_shift = {sh[DW-2:0], di_i};
  assign cmd_now    = decode_cmd(opc, addr_shift[AW-1 -: 2]);
  assign rd_addr    = (state == ST_ADDR) ? addr_shift : AW'(wrap_inc(32'(addr), DEPTH));
  assign rd_active  = (state == ST_READ);
  assign prog_start = cs_fall & (pend_page | pend_all);

  assign do_oe_o = cs_i & (rd_active | busy | rdy);
  assign do_o    = rd_active ? out_bit : ~busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cmd       <= CMD_NONE;
      cnt       <= '0;
      opc       <= '0;
      addr      <= '0;
      sh        <= '0;
      out_bit   <= 1'b0;
      wen       <= 1'b0;
      rdy       <= 1'b0;
      pend_page <= 1'b0;
      pend_all  <= 1'b0;
      all_val   <= '1;
      ptr       <= '0;
      pg_base   <= '0;
      pg_valid  <= '0;
      pg_data   <= '1;
    end else begin
      if (prog_done) rdy <= 1'b1;
      if (!cs_i) begin
        state <= ST_IDLE;
        cnt   <= '0;
        if (cs_fall) begin
          pend_page <= 1'b0;
          pend_all  <= 1'b0;
        end
      end else if (sk_rise) begin
        case (state)
          ST_IDLE: begin
            if (di_i && !busy) begin
              state <= ST_OPC;
              cnt   <= '0;
              rdy   <= 1'b0;
            end
          end
          ST_OPC: begin
            opc <= {opc[0], di_i};
            if (cnt == CW'(1)) begin
              state <= ST_ADDR;
              cnt   <= '0;
            end else cnt <= cnt + 1'b1;
          end
          ST_ADDR: begin
            addr <= addr_shift;
            if (cnt == ADDR_LAST) begin
              cnt <= '0;
              cmd <= cmd_now;
              case (cmd_now)
                CMD_READ: begin
                  state   <= ST_READ;
                  out_bit <= 1'b0;
                  sh      <= rd_word;
                  cnt     <= DATA_CNT;
                end
                CMD_WRITE: begin
                  if (wen) begin
                    state    <= ST_DATA;
                    ptr      <= addr_shift[PB-1:0];
                    pg_base  <= addr_shift[AW-1:PB];
                    pg_valid <= '0;
                  end else state <= ST_HOLD;
                end
                CMD_WRAL: state <= wen ? ST_DATA : ST_HOLD;
                CMD_ERASE: begin
                  state <= ST_HOLD;
                  if (wen) begin
                    pg_base   <= addr_shift[AW-1:PB];
                    pg_valid  <= SLOTS'(1) << addr_shift[PB-1:0];
                    pg_data[int'(addr_shift[PB-1:0])*DW +: DW] <= '1;
                    pend_page <= 1'b1;
                  end
                end
                CMD_ERAL: begin
                  state <= ST_HOLD;
                  if (wen) begin
                    all_val  <= '1;
                    pend_all <= 1'b1;
                  end
                end
                CMD_EWEN: begin wen <= 1'b1; state <= ST_HOLD; end
                CMD_EWDS: begin wen <= 1'b0; state <= ST_HOLD; end
                default:  state <= ST_HOLD;
              endcase
            end else cnt <= cnt + 1'b1;
          end
          ST_DATA: begin
            sh <= data_shift;
            if (cnt == DATA_LAST) begin
              cnt <= '0;
              if (cmd == CMD_WRITE) begin
                pg_data[int'(ptr)*DW +: DW] <= data_shift;
                pg_valid[ptr] <= 1'b1;
                ptr           <= PB'(wrap_inc(32'(ptr), SLOTS));
                pend_page     <= 1'b1;
              end else begin
                all_val  <= data_shift;
                pend_all <= 1'b1;
                state    <= ST_HOLD;
              end
            end else cnt <= cnt + 1'b1;
          end
          ST_READ: begin
            if (cnt == '0) begin
              out_bit <= rd_word[DW-1];
              sh      <= {rd_word[DW-2:0], 1'b0};
              cnt     <= DATA_LAST;
              addr    <= rd_addr;
            end else begin
              out_bit <= sh[DW-1];
              sh      <= {sh[DW-2:0], 1'b0};
              cnt     <= cnt - 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // a cycle only begins right after select falls
  p_prog_at_cs_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cs_fall));
  // a cycle only begins while alteration is enabled
  p_prog_needs_wen_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wen));
  // while selected during a cycle the output shows busy low
  p_busy_shows_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cs_i) |-> (do_oe_o && !do_o));
  // the reply opens with a zero
  p_dummy_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_active) |-> !out_bit);
  // ready persists until a start bit is taken
  p_ready_until_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy && !(sk_rise && di_i)) |=> rdy);
endmodule

// File: tb/test_mw_serial_mem.sv
`timescale 1ns/1ps
module test_mw_serial_mem;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs = 1'b0, sk = 1'b0, di = 1'b0;
  logic do_v, do_oe;
  int n_tests = 0;
  int n_fail = 0;
  bit finished = 1'b0;
  logic [7:0] rbuf [4];

  always #2.5 clk = ~clk;

  mw_serial_mem #(.WORD16(1'b0), .PROG_CYCLES(50)) i_mw_serial_mem (
    .clk(clk), .rst_n(rst_n), .cs_i(cs), .sk_i(sk), .di_i(di),
    .do_o(do_v), .do_oe_o(do_oe)
  );

  // row: kind(3) addr(7) data(8) expect(8) prog(1)
  // kind 0 read, 1 write, 2 erase, 3 enable, 4 disable, 5 erase all, 6 write all
  localparam int NROWS = 19;
  localparam logic [26:0] VEC [NROWS] = '{
    {3'd0, 7'h05, 8'h00, 8'hFF, 1'b0},
    {3'd1, 7'h05, 8'h3C, 8'h00, 1'b0},
    {3'd0, 7'h05, 8'h00, 8'hFF, 1'b0},
    {3'd3, 7'h00, 8'h00, 8'h00, 1'b0},
    {3'd1, 7'h05, 8'h3C, 8'h00, 1'b1},
    {3'd0, 7'h05, 8'h00, 8'h3C, 1'b0},
    {3'd1, 7'h7F, 8'hA5, 8'h00, 1'b1},
    {3'd0, 7'h7F, 8'h00, 8'hA5, 1'b0},
    {3'd2, 7'h05, 8'h00, 8'h00, 1'b1},
    {3'd0, 7'h05, 8'h00, 8'hFF, 1'b0},
    {3'd6, 7'h00, 8'h5A, 8'h00, 1'b1},
    {3'd0, 7'h00, 8'h00, 8'h5A, 1'b0},
    {3'd0, 7'h7F, 8'h00, 8'h5A, 1'b0},
    {3'd5, 7'h00, 8'h00, 8'h00, 1'b1},
    {3'd0, 7'h40, 8'h00, 8'hFF, 1'b0},
    {3'd1, 7'h10, 8'h81, 8'h00, 1'b1},
    {3'd4, 7'h00, 8'h00, 8'h00, 1'b0},
    {3'd2, 7'h10, 8'h00, 8'h00, 1'b0},
    {3'd0, 7'h10, 8'h00, 8'h81, 1'b0}
  };

  task automatic clk_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic bit_out(input logic b);
    di = b; sk = 1'b1; clk_n(2);
    sk = 1'b0; clk_n(2);
  endtask

  task automatic sel();
    cs = 1'b1; clk_n(2);
  endtask

  task automatic desel();
    cs = 1'b0; di = 1'b0; sk = 1'b0; clk_n(2);
  endtask

  task automatic send_hdr(input logic [1:0] op, input logic [6:0] a);
    bit_out(1'b1);
    bit_out(op[1]); bit_out(op[0]);
    for (int i = 6; i >= 0; i--) bit_out(a[i]);
  endtask

  task automatic send_byte(input logic [7:0] d);
    for (int i = 7; i >= 0; i--) bit_out(d[i]);
  endtask

  task automatic do_read(input logic [6:0] a, input int n);
    sel();
    send_hdr(2'b10, a);
    chk(do_oe === 1'b1 && do_v === 1'b0, "R3", "dummy zero", {do_oe, do_v}, 2'b10);
    for (int w = 0; w < n; w++) begin
      logic [7:0] v = '0;
      for (int b = 0; b < 8; b++) begin
        bit_out(1'b0);
        v = {v[6:0], do_v};
      end
      rbuf[w] = v;
    end
    desel();
  endtask

  task automatic wait_ready(input bit prog);
    sel();
    if (prog) begin
      chk(do_oe === 1'b1 && do_v === 1'b0, "R8", "busy shown", {do_oe, do_v}, 2'b10);
      for (int k = 0; k < 400 && do_v !== 1'b1; k++) clk_n(1);
      chk(do_oe === 1'b1 && do_v === 1'b1, "R8", "ready shown", {do_oe, do_v}, 2'b11);
    end else begin
      chk(do_oe === 1'b0, "R5", "no cycle when disabled", do_oe, 0);
    end
    desel();
  endtask

  task automatic write_byte(input logic [6:0] a, input logic [7:0] d);
    sel(); send_hdr(2'b01, a); send_byte(d); desel(); wait_ready(1'b1);
  endtask

  task automatic exec_row(input int r);
    logic [2:0] kind = VEC[r][26:24];
    logic [6:0] a    = VEC[r][23:17];
    logic [7:0] d    = VEC[r][16:9];
    logic [7:0] e    = VEC[r][8:1];
    bit         p    = VEC[r][0];
    case (kind)
      3'd0: begin
        do_read(a, 1);
        chk(rbuf[0] === e, "R2/R5/R6", $sformatf("row %0d read", r), rbuf[0], e);
      end
      3'd1: begin sel(); send_hdr(2'b01, a); send_byte(d); desel(); wait_ready(p); end
      3'd2: begin sel(); send_hdr(2'b11, a); desel(); wait_ready(p); end
      3'd3: begin sel(); send_hdr(2'b00, 7'b1100000); desel(); end
      3'd4: begin sel(); send_hdr(2'b00, 7'b0000000); desel(); end
      3'd5: begin sel(); send_hdr(2'b00, 7'b1000000); desel(); wait_ready(p); end
      default: begin sel(); send_hdr(2'b00, 7'b0100000); send_byte(d); desel(); wait_ready(p); end
    endcase
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    clk_n(3);
    rst_n = 1'b1;
    clk_n(2);
    // R12: output released after reset
    chk(do_oe === 1'b0, "R12", "released after reset", do_oe, 0);
    sel();
    chk(do_oe === 1'b0, "R11", "selected but idle", do_oe, 0);
    desel();

    for (int r = 0; r < NROWS; r++) exec_row(r);

    // R1: leading zeros before the start bit are skipped
    sel(); bit_out(1'b0); bit_out(1'b0);
    send_hdr(2'b10, 7'h10);
    chk(do_oe === 1'b1 && do_v === 1'b0, "R1", "dummy after zeros", {do_oe, do_v}, 2'b10);
    begin
      logic [7:0] v = '0;
      for (int b = 0; b < 8; b++) begin bit_out(1'b0); v = {v[6:0], do_v}; end
      chk(v === 8'h81, "R1", "read after leading zeros", v, 8'h81);
    end
    desel();

    // R7: page write wraps in the low 4 bits, partial unit dropped
    sel(); send_hdr(2'b00, 7'b1100000); desel();
    sel(); send_hdr(2'b01, 7'h1E);
    send_byte(8'h11); send_byte(8'h22); send_byte(8'h33);
    bit_out(1'b1); bit_out(1'b0); bit_out(1'b1); bit_out(1'b0);
    desel(); wait_ready(1'b1);
    do_read(7'h1E, 3);
    chk(rbuf[0] === 8'h11, "R7", "page slot 1E", rbuf[0], 8'h11);
    chk(rbuf[1] === 8'h22, "R7", "page slot 1F", rbuf[1], 8'h22);
    chk(rbuf[2] === 8'hFF, "R4", "continuous into 20", rbuf[2], 8'hFF);
    do_read(7'h10, 1);
    chk(rbuf[0] === 8'h33, "R7", "wrapped to 10", rbuf[0], 8'h33);
    do_read(7'h1D, 1);
    chk(rbuf[0] === 8'hFF, "R7", "1D untouched", rbuf[0], 8'hFF);

    // R4: continuous read rolls from top to 0
    write_byte(7'h7F, 8'h7E);
    write_byte(7'h00, 8'hC3);
    do_read(7'h7F, 2);
    chk(rbuf[0] === 8'h7E, "R4", "top location", rbuf[0], 8'h7E);
    chk(rbuf[1] === 8'hC3, "R4", "rolled to 0", rbuf[1], 8'hC3);

    // R10: disable sent while busy is ignored
    sel(); send_hdr(2'b01, 7'h40); send_byte(8'h99); desel();
    sel();
    chk(do_oe === 1'b1 && do_v === 1'b0, "R8", "busy right after start", {do_oe, do_v}, 2'b10);
    send_hdr(2'b00, 7'b0000000);
    for (int k = 0; k < 400 && do_v !== 1'b1; k++) clk_n(1);
    chk(do_v === 1'b1, "R8", "ready without SK", do_v, 1);
    desel();
    write_byte(7'h41, 8'h66);
    do_read(7'h41, 1);
    chk(rbuf[0] === 8'h66, "R10", "still enabled", rbuf[0], 8'h66);
    do_read(7'h40, 1);
    chk(rbuf[0] === 8'h99, "R6", "busy-time write landed", rbuf[0], 8'h99);

    // R9: ready held across deselect until a start bit
    sel(); send_hdr(2'b01, 7'h42); send_byte(8'h5A); desel();
    sel();
    for (int k = 0; k < 400 && do_v !== 1'b1; k++) clk_n(1);
    desel(); clk_n(3); sel();
    chk(do_oe === 1'b1 && do_v === 1'b1, "R9", "ready after reselect", {do_oe, do_v}, 2'b11);
    bit_out(1'b0);
    chk(do_oe === 1'b1 && do_v === 1'b1, "R9", "ready after zero bit", {do_oe, do_v}, 2'b11);
    bit_out(1'b1);
    chk(do_oe === 1'b0, "R9", "cleared by start bit", do_oe, 0);
    desel();

    // R6: incomplete data unit starts nothing
    sel(); send_hdr(2'b01, 7'h50);
    for (int i = 0; i < 5; i++) bit_out(1'b0);
    desel(); sel();
    chk(do_oe === 1'b0, "R6", "no cycle for partial unit", do_oe, 0);
    desel();
    do_read(7'h50, 1);
    chk(rbuf[0] === 8'hFF, "R6", "partial unit not stored", rbuf[0], 8'hFF);

    // R11: CS low mid-read abandons the frame
    sel(); send_hdr(2'b10, 7'h41); bit_out(1'b0); bit_out(1'b0); bit_out(1'b0);
    desel();
    chk(do_oe === 1'b0, "R11", "released when CS low", do_oe, 0);
    sel();
    chk(do_oe === 1'b0, "R11", "no leftover reply", do_oe, 0);
    desel();
    do_read(7'h41, 1);
    chk(rbuf[0] === 8'h66, "R11", "fresh read after abort", rbuf[0], 8'h66);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule